// File: doc/BRIEF.md
# Interrupt Group State Sensing Unit

This block keeps the state of a bank of interrupt levels, organised as up to 16 groups of 16 levels each. Every level carries a four-valued arm state (disarmed, armed, waiting, active) and a separate enable flag. A plain command port advances a single level through its arm sequence or sets and clears its enable flag, one level per cycle.

Software-visible state is read through a sense request. A request carries an effective address. The group number and a 3-bit function code are decoded from fixed fields of that address. The block answers with a 32-bit word holding one bit per level of the chosen group. Each bit is set when its level meets the condition that the function code names. The word is packed so that the highest-priority level, which is the lowest-numbered one, sits at bit 15.

Requests and responses are valid/ready streams. A request is taken in any cycle where `req_valid` and `req_ready` are both high, and its response is registered and shown on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds still and `req_ready` stays low. That back-pressure reaches the requester in the same cycle. A response slot that drains in a cycle can take a new request in that same cycle.

Top module: `irq_group_sense`

## Requirements
- R1: After reset every level is disarmed with its enable flag clear, `rsp_valid` is low, and every sense code returns 0 for every group.
- R2: The group number is `req_addr[3:0]` and the function code is `req_addr[10:8]` (bit 8 least significant). All other address bits have no effect on the response.
- R3: Code 3'b001 sets the bit of each level of the group that is armed or waiting, and clears all other bits.
- R4: Code 3'b010 sets the bit of each level that is waiting or active, and clears all other bits.
- R5: Code 3'b100 sets the bit of each level whose enable flag is set, and clears all other bits.
- R6: Any other code (000, 011, 101, 110, 111) returns an all-zero word.
- R7: Level k of the group is reported at result bit 15-k, where bit 0 is the least significant bit. Result bits 31:16 are always zero.
- R8: The `cmd_op` values act as follows:
  - 1 (arm) moves disarmed to armed.
  - 2 (trigger) moves armed to waiting.
  - 3 (acknowledge) moves waiting to active.
  - 4 (clear) moves active to disarmed.
  - An op applied to a level in any other state leaves that level unchanged. Op 0 does nothing.
- R9: `cmd_op` 5 sets the enable flag and 6 clears it, without touching the arm state. Op 7 has no effect.
- R10: A request accepted in the same cycle as a command reports the state from before that command.
- R11: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request gives `rsp_valid` on the next cycle. A response that is stalled keeps its data unchanged.
- R12: A command changes only the level named by `cmd_group` and `cmd_level`, and only when `cmd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Apply `cmd_op` this cycle |
| cmd_group | input | 4 | Group of the level being updated |
| cmd_level | input | 4 | Level within the group |
| cmd_op | input | 3 | State operation (see R8, R9) |
| req_valid | input | 1 | Sense request present |
| req_ready | output | 1 | Sense request can be taken |
| req_addr | input | 32 | Effective address carrying group and code |
| rsp_valid | output | 1 | Response word present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Sensed level bits |

## Verification
The assertions assume that the command inputs and `rsp_ready` hold known values whenever reset is released. They also assume that `cmd_group` names an existing group, because a command for a missing group would change no level. The stimulus drives every input from defined values on each cycle and draws command groups only from the populated range. It steers most traffic onto a few groups so that levels reach every arm state, and it stalls the response side at random so that the hold rule is exercised.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

  typedef enum logic [1:0] {
    LV_IDLE   = 2'd0,
    LV_ARMED  = 2'd1,
    LV_WAIT   = 2'd2,
    LV_ACTIVE = 2'd3
  } lvl_state_e;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ARM    = 3'd1,
    OP_TRIG   = 3'd2,
    OP_ACK    = 3'd3,
    OP_CLR    = 3'd4,
    OP_EN_SET = 3'd5,
    OP_EN_CLR = 3'd6,
    OP_RSVD   = 3'd7
  } lvl_op_e;

  localparam logic [2:0] FC_ARM_OR_WAIT = 3'b001;
  localparam logic [2:0] FC_WAIT_OR_ACT = 3'b010;
  localparam logic [2:0] FC_ENABLED     = 3'b100;

  localparam int GRP_FIELD_W  = 4;
  localparam int CODE_FIELD_W = 3;

endpackage

// File: rtl/irq_level_cell.sv
module irq_level_cell
  import irq_sense_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic [2:0] op,
  output logic       armed,
  output logic       waiting,
  output logic       active,
  output logic       enabled
);

  lvl_state_e st, st_nxt;
  lvl_op_e    op_e;
  logic       en_q, en_nxt;

  assign op_e = lvl_op_e'(op);

  always_comb begin
    st_nxt = st;
    unique case (op_e)
      OP_ARM:  if (st == LV_IDLE)   st_nxt = LV_ARMED;
      OP_TRIG: if (st == LV_ARMED)  st_nxt = LV_WAIT;
      OP_ACK:  if (st == LV_WAIT)   st_nxt = LV_ACTIVE;
      OP_CLR:  if (st == LV_ACTIVE) st_nxt = LV_IDLE;
      default: st_nxt = st;
    endcase
  end

  always_comb begin
    en_nxt = en_q;
    if (op_e == OP_EN_SET)      en_nxt = 1'b1;
    else if (op_e == OP_EN_CLR) en_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= LV_IDLE;
      en_q <= 1'b0;
    end else if (sel) begin
      st   <= st_nxt;
      en_q <= en_nxt;
    end
  end

  assign armed   = (st == LV_ARMED);
  assign waiting = (st == LV_WAIT);
  assign active  = (st == LV_ACTIVE);
  assign enabled = en_q;

  // R8
  arm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op_e == OP_ARM && st == LV_IDLE) |=> (st == LV_ARMED));

  // R8
  trig_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op_e == OP_TRIG && st == LV_ARMED) |=> (st == LV_WAIT));

  // R8
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LV_IDLE) |=> (st == LV_IDLE || st == LV_ARMED));

  // R9
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op_e == OP_EN_SET) |=> (en_q && $stable(st)));

  // R12
  unselected_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(st) && $stable(en_q)));

endmodule

// File: rtl/irq_group_bank.sv
module irq_group_bank #(
  parameter int NUM_GROUPS = 16,
  parameter int LEVELS     = 16,
  localparam int GW        = $clog2(NUM_GROUPS),
  localparam int LW        = $clog2(LEVELS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cmd_valid,
  input  logic [GW-1:0]                     cmd_group,
  input  logic [LW-1:0]                     cmd_level,
  input  logic [2:0]                        cmd_op,
  output logic [NUM_GROUPS-1:0][LEVELS-1:0] armed_o,
  output logic [NUM_GROUPS-1:0][LEVELS-1:0] waiting_o,
  output logic [NUM_GROUPS-1:0][LEVELS-1:0] active_o,
  output logic [NUM_GROUPS-1:0][LEVELS-1:0] enabled_o
);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic grp_hit;
    assign grp_hit = cmd_valid && (cmd_group == GW'(g));
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      logic lvl_sel;
      assign lvl_sel = grp_hit && (cmd_level == LW'(l));
      irq_level_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (lvl_sel),
        .op      (cmd_op),
        .armed   (armed_o[g][l]),
        .waiting (waiting_o[g][l]),
        .active  (active_o[g][l]),
        .enabled (enabled_o[g][l])
      );
    end
  end

  // R12
  one_level_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(armed_o) && $stable(waiting_o) &&
                    $stable(active_o) && $stable(enabled_o)));

endmodule

// File: rtl/irq_sense_select.sv
module irq_sense_select
  import irq_sense_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter int LEVELS     = 16,
  parameter int DATA_W     = 32,
  localparam int GW        = $clog2(NUM_GROUPS)
) (
  input  logic [GRP_FIELD_W-1:0]            grp,
  input  logic [CODE_FIELD_W-1:0]           code,
  input  logic [NUM_GROUPS-1:0][LEVELS-1:0] armed_i,
  input  logic [NUM_GROUPS-1:0][LEVELS-1:0] waiting_i,
  input  logic [NUM_GROUPS-1:0][LEVELS-1:0] active_i,
  input  logic [NUM_GROUPS-1:0][LEVELS-1:0] enabled_i,
  output logic [DATA_W-1:0]                 word
);

  logic [GW-1:0]     gidx;
  logic              grp_ok;
  logic [LEVELS-1:0] hit;

  assign gidx   = grp[GW-1:0];
  assign grp_ok = (int'(grp) < NUM_GROUPS);

  always_comb begin
    hit = '0;
    if (grp_ok) begin
      unique case (code)
        FC_ARM_OR_WAIT: hit = armed_i[gidx]   | waiting_i[gidx];
        FC_WAIT_OR_ACT: hit = waiting_i[gidx] | active_i[gidx];
        FC_ENABLED:     hit = enabled_i[gidx];
        default:        hit = '0;
      endcase
    end
  end

  // Level 0 is the highest priority and lands on the topmost bit of the
  // low half; the upper half of the word is left zero.
  always_comb begin
    word = '0;
    for (int k = 0; k < LEVELS; k++) begin
      word[LEVELS-1-k] = hit[k];
    end
  end

endmodule

// File: rtl/irq_group_sense.sv
module irq_group_sense
  import irq_sense_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter int LEVELS     = 16,
  parameter int DATA_W     = 32,
  parameter int GRP_LSB    = 0,
  parameter int CODE_LSB   = 8,
  localparam int GW        = $clog2(NUM_GROUPS),
  localparam int LW        = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [GW-1:0]     cmd_group,
  input  logic [LW-1:0]     cmd_level,
  input  logic [2:0]        cmd_op,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);

  logic [NUM_GROUPS-1:0][LEVELS-1:0] armed_v, waiting_v, active_v, enabled_v;
  logic [GRP_FIELD_W-1:0]  req_grp;
  logic [CODE_FIELD_W-1:0] req_code;
  logic [DATA_W-1:0]       sense_word;
  logic                    accept;

  assign req_grp  = req_addr[GRP_LSB +: GRP_FIELD_W];
  assign req_code = req_addr[CODE_LSB +: CODE_FIELD_W];

  irq_group_bank #(
    .NUM_GROUPS (NUM_GROUPS),
    .LEVELS     (LEVELS)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_group (cmd_group),
    .cmd_level (cmd_level),
    .cmd_op    (cmd_op),
    .armed_o   (armed_v),
    .waiting_o (waiting_v),
    .active_o  (active_v),
    .enabled_o (enabled_v)
  );

  irq_sense_select #(
    .NUM_GROUPS (NUM_GROUPS),
    .LEVELS     (LEVELS),
    .DATA_W     (DATA_W)
  ) u_select (
    .grp       (req_grp),
    .code      (req_code),
    .armed_i   (armed_v),
    .waiting_i (waiting_v),
    .active_i  (active_v),
    .enabled_i (enabled_v),
    .word      (sense_word)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (accept) begin
        rsp_data <= sense_word;
      end
      rsp_valid <= accept || (rsp_valid && !rsp_ready);
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R11
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data[DATA_W-1:LEVELS] == '0));

  // R6
  bad_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_code != FC_ARM_OR_WAIT && req_code != FC_WAIT_OR_ACT &&
     req_code != FC_ENABLED) |=> (rsp_data == '0));

endmodule

// File: tb/irq_group_sense_bench.sv
module irq_group_sense_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd_group;
  logic [3:0]  cmd_level;
  logic [2:0]  cmd_op;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [31:0] rsp_data;

  always #5 clk = ~clk;

  irq_group_sense u_irq_group_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_group (cmd_group),
    .cmd_level (cmd_level),
    .cmd_op    (cmd_op),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // Behavioural model: 0 disarmed, 1 armed, 2 waiting, 3 active
  int          mst [16][16];
  bit          men [16][16];
  bit          mv;
  logic [31:0] md;
  string       mtag;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] msense(input logic [31:0] a);
    logic [31:0] r = '0;
    int g = int'(a[3:0]);
    logic [2:0] c = a[10:8];
    for (int k = 0; k < 16; k++) begin
      bit h = 1'b0;
      if (c == 3'b001)      h = (mst[g][k] == 1 || mst[g][k] == 2);
      else if (c == 3'b010) h = (mst[g][k] == 2 || mst[g][k] == 3);
      else if (c == 3'b100) h = men[g][k];
      r[15-k] = h;
    end
    return r;
  endfunction

  function automatic string code_tag(input logic [31:0] a);
    case (a[10:8])
      3'b001:  return "R3";
      3'b010:  return "R4";
      3'b100:  return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic mapply(input int g, input int l, input int op);
    case (op)
      1: if (mst[g][l] == 0) mst[g][l] = 1;
      2: if (mst[g][l] == 1) mst[g][l] = 2;
      3: if (mst[g][l] == 2) mst[g][l] = 3;
      4: if (mst[g][l] == 3) mst[g][l] = 0;
      5: men[g][l] = 1'b1;
      6: men[g][l] = 1'b0;
      default: ;
    endcase
  endtask

  // One clock: drive, compare registered outputs with model, advance model.
  task automatic step(input bit cv, input int cg, input int cl, input int op,
                      input bit rv, input logic [31:0] ra, input bit rr,
                      input string tag);
    @(negedge clk);
    cmd_valid = cv;
    cmd_group = 4'(cg);
    cmd_level = 4'(cl);
    cmd_op    = 3'(op);
    req_valid = rv;
    req_addr  = ra;
    rsp_ready = rr;
    #1;
    chk("R11", {31'b0, rsp_valid}, {31'b0, mv});
    if (mv) begin
      chk(mtag, rsp_data, md);
      chk("R7", {16'b0, rsp_data[31:16]}, 32'h0);
    end
    chk("R11", {31'b0, req_ready}, {31'b0, (!mv || rr)});
    if (rv && (!mv || rr)) begin
      md   = msense(ra);
      mv   = 1'b1;
      mtag = (tag != "") ? tag : code_tag(ra);
    end else if (rr) begin
      mv = 1'b0;
    end
    if (cv) mapply(cg, cl, op);
  endtask

  function automatic logic [31:0] addr(input int g, input int c);
    return {21'b0, 3'(c), 4'b0, 4'(g)};
  endfunction

  task automatic cmd(input int g, input int l, input int op);
    step(1'b1, g, l, op, 1'b0, 32'h0, 1'b1, "");
  endtask

  task automatic sense(input int g, input int c, input string tag);
    step(1'b0, 0, 0, 0, 1'b1, addr(g, c), 1'b1, tag);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog expired got 0 exp 1");
      summary();
      $finish;
    end
  end

  initial begin
    foreach (mst[g, l]) begin
      mst[g][l] = 0;
      men[g][l] = 1'b0;
    end
    mv = 1'b0; md = '0; mtag = "R1";
    rst_n = 1'b0;
    cmd_valid = 0; cmd_group = 0; cmd_level = 0; cmd_op = 0;
    req_valid = 0; req_addr = 0; rsp_ready = 1;
    repeat (3) @(negedge clk);
    chk("R1", {31'b0, rsp_valid}, 32'h0);
    rst_n = 1'b1;

    // R1: everything reads zero after reset
    for (int g = 0; g < 16; g++) begin
      sense(g, 1, "R1");
      sense(g, 2, "R1");
      sense(g, 4, "R1");
    end

    // R8 / R3 / R4: walk one level through its sequence
    cmd(1, 0, 1);  sense(1, 1, "R3");
    cmd(1, 0, 2);  sense(1, 1, "R3"); sense(1, 2, "R4");
    cmd(1, 0, 3);  sense(1, 2, "R4"); sense(1, 1, "R8");
    cmd(1, 0, 4);  sense(1, 2, "R8"); sense(1, 1, "R8");
    // R8: out-of-order ops have no effect
    cmd(1, 3, 2);  cmd(1, 3, 3); cmd(1, 3, 4); sense(1, 1, "R8"); sense(1, 2, "R8");
    cmd(1, 3, 1);  cmd(1, 3, 1); cmd(1, 3, 3); cmd(1, 3, 4); sense(1, 1, "R8"); sense(1, 2, "R8");

    // R9 / R5: enable independent of arm state
    cmd(2, 15, 5); sense(2, 5 - 1, "R5"); sense(2, 1, "R9");
    cmd(2, 15, 1); cmd(2, 15, 6); sense(2, 4, "R9"); sense(2, 1, "R9");
    cmd(2, 15, 5); cmd(2, 15, 7); cmd(2, 15, 0); sense(2, 4, "R9"); sense(2, 1, "R9");

    // R7: bit ordering at both ends
    cmd(4, 0, 5);  sense(4, 4, "R7");
    cmd(4, 15, 1); cmd(4, 15, 2); sense(4, 1, "R7"); sense(4, 2, "R7");

    // R6: undefined codes on a group with every state present
    cmd(5, 0, 1);
    cmd(5, 1, 1); cmd(5, 1, 2);
    cmd(5, 2, 1); cmd(5, 2, 2); cmd(5, 2, 3);
    cmd(5, 3, 5);
    foreach (mst[0][c]) if (c < 8 && c != 1 && c != 2 && c != 4) sense(5, c, "R6");

    // R2: stray address bits are ignored
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a = $urandom();
      a[10:8] = 3'(1 << (i % 3));
      a[3:0]  = 4'd5;
      step(1'b0, 0, 0, 0, 1'b1, a, 1'b1, "R2");
    end

    // R10: sense in the same cycle as an update sees the old state
    step(1'b1, 6, 2, 1, 1'b1, addr(6, 1), 1'b1, "R10");
    step(1'b1, 6, 2, 2, 1'b1, addr(6, 2), 1'b1, "R10");
    step(1'b1, 6, 2, 5, 1'b1, addr(6, 4), 1'b1, "R10");
    sense(6, 2, "R10");

    // R12: neighbours untouched
    cmd(3, 7, 1); cmd(3, 7, 5);
    step(1'b0, 3, 8, 1, 1'b0, 32'h0, 1'b1, "");
    sense(2, 1, "R12"); sense(4, 1, "R12"); sense(3, 1, "R12"); sense(3, 4, "R12");

    // R11: back-pressure holds the response
    step(1'b0, 0, 0, 0, 1'b1, addr(5, 2), 1'b0, "R11");
    step(1'b0, 0, 0, 0, 1'b1, addr(5, 1), 1'b0, "R11");
    step(1'b0, 0, 0, 0, 1'b1, addr(5, 1), 1'b0, "R11");
    step(1'b0, 0, 0, 0, 1'b1, addr(5, 1), 1'b1, "R11");
    step(1'b0, 0, 0, 0, 1'b0, 32'h0, 1'b1, "R11");

    // Random traffic concentrated on a few groups
    for (int i = 0; i < 4000; i++) begin
      int g  = ($urandom_range(0, 9) < 8) ? $urandom_range(0, 2) : $urandom_range(0, 15);
      int sg = ($urandom_range(0, 9) < 8) ? $urandom_range(0, 2) : $urandom_range(0, 15);
      logic [31:0] a = $urandom();
      a[3:0]  = 4'(sg);
      if ($urandom_range(0, 9) < 8) a[10:8] = 3'(1 << $urandom_range(0, 2));
      step($urandom_range(0, 3) != 0, g, $urandom_range(0, 15), $urandom_range(0, 7),
           $urandom_range(0, 2) != 0, a, $urandom_range(0, 3) != 0, "");
    end

    step(1'b0, 0, 0, 0, 1'b0, 32'h0, 1'b1, "");
    step(1'b0, 0, 0, 0, 1'b0, 32'h0, 1'b1, "");
    done = 1'b1;
    summary();
    $finish;
  end

endmodule